// File: doc/BRIEF.md
# Low-Side Switch Fault Supervisor

This block is the digital supervisor for one low-side power switch. It takes an enable and a control input, together with seven raw comparator flags from the analog front end. From these it produces the gate-on command for the power stage and a single status bit for the host. The flags are: overload, overtemperature, power-ground loss, signal-ground loss, under-current open load, off-state under-voltage open load, and active output clamp. Every input passes through a two-flop synchroniser. All timing constants are parameters in clock cycles.

Faults fall into two classes. A severe fault (overload, overtemperature, either ground loss) sets a latch that turns the switch off. Only a sustained low command clears it. A warning fault (either open-load kind, or an active clamp) inverts the status but leaves the switch on, and it clears by itself after a quiet interval. Status reports the commanded state through a retriggerable off-delay, so a fast PWM control input yields a steady level. Any stored fault inverts that level.

Top module: `lsd_diag_channel`

## Requirements
- R1: `gate_o` is high only when the synchronised enable and control inputs are both high and the shutdown latch is clear. Enable low forces `gate_o` low whatever the control input is.
- R2: With no stored fault, `stat_o` is high while the switch is commanded on and low once it has been commanded off for HOLD_CYC cycles.
- R3: Overload (`ovl_i`), overtemperature (`otemp_i`), power-ground loss (`pgnd_i`) and signal-ground loss (`sgnd_i`), once accepted, set the shutdown latch. The latch forces `gate_o` low and inverts `stat_o`.
- R4: The shutdown latch clears only after enable or control has been low for HOLD_CYC consecutive synchronised cycles. Toggling the control faster than that keeps the latch set.
- R5: Under-current (`ucur_i`), under-voltage (`uvolt_i`) and clamp (`clamp_i`) set a warning register. The warning register inverts `stat_o` but leaves `gate_o` unchanged. It clears after HOLD_CYC consecutive cycles with no accepted warning.
- R6: A flag other than `clamp_i` is accepted only after FILT_CYC consecutive qualified synchronised samples (FILT_OFF_CYC for `uvolt_i`). A shorter pulse is ignored. `clamp_i` acts without filtering.
- R7: `ovl_i` and `ucur_i` count only while commanded on. `uvolt_i` counts only while enable is high and control is low. `otemp_i`, `pgnd_i` and `sgnd_i` count in any state.
- R8: The status off-transition is delayed by HOLD_CYC cycles and retriggered by each on phase, so a control input whose low phases are shorter than HOLD_CYC keeps `stat_o` steadily high.
- R9: Clamp events separated by gaps shorter than HOLD_CYC keep `stat_o` continuously inverted.
- R10: An input change reaches `gate_o` after two rising clock edges. Synchronous reset (`rst_n` low) clears every latch and drives `gate_o` and `stat_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Channel enable, asynchronous |
| ctl_i | input | 1 | Switch control, asynchronous |
| ovl_i | input | 1 | Raw overload comparator |
| otemp_i | input | 1 | Raw overtemperature comparator |
| pgnd_i | input | 1 | Raw power-ground loss comparator |
| sgnd_i | input | 1 | Raw signal-ground loss comparator |
| ucur_i | input | 1 | Raw on-state under-current comparator |
| uvolt_i | input | 1 | Raw off-state under-voltage comparator |
| clamp_i | input | 1 | Raw output clamp active |
| gate_o | output | 1 | Gate-on command to the power stage |
| stat_o | output | 1 | Status bit, inverted on any stored fault |

## Verification
The hardest state to reach from the ports is a shutdown latch that must survive a control input toggling faster than the release delay. Reaching it needs an accepted overload while commanded on, then removal of the flag, then low phases that always stay short of HOLD_CYC. The bench builds this state in that order and checks the gate at every cycle of the toggling. It then verifies release after one long low phase. Repeated clamp pulses with short gaps, and sub-filter glitches on a running switch, are produced in the same directed style. Every cycle is also compared against a reference model kept in the bench.

// File: rtl/lsd_diag_pkg.sv
`timescale 1ns/1ps
// Package: shared flag indices and vector type for the switch supervisor.
// Assumes flags 0..3 are severe, 4..5 filtered warnings, 6 unfiltered warning.
package lsd_diag_pkg;
    localparam int NFLAG    = 7;
    localparam int NFILT    = 6;
    localparam int FL_OVL   = 0;
    localparam int FL_OTEMP = 1;
    localparam int FL_PGND  = 2;
    localparam int FL_SGND  = 3;
    localparam int FL_UCUR  = 4;
    localparam int FL_UVOLT = 5;
    localparam int FL_CLAMP = 6;
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/lsd_sync.sv
`timescale 1ns/1ps
// Module: two-flop synchroniser for a bundle of independent asynchronous bits.
// Assumes the bits need no mutual coherence.
module lsd_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/lsd_flag_filter.sv
`timescale 1ns/1ps
// Module: persistence filter. hit_o rises after LEN consecutive high samples
// of flag_i and falls on the first low sample; a short pulse restarts the count.
// Assumes LEN >= 1 and flag_i is already synchronous and qualified.
module lsd_flag_filter #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic hit_o
);
    localparam int            CW   = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive samples; hold hit while the flag stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_o <= 1'b0;
        end else if (!flag_i) begin
            cnt_q <= '0;
            hit_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            hit_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (LEN >= 2) begin : g_chk
            // R6: acceptance needs at least two consecutive high samples here
            a_r6_filter_persist: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(hit_o) |-> ($past(flag_i) && $past(flag_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/lsd_quiet_timer.sv
`timescale 1ns/1ps
// Module: saturating counter of consecutive quiet cycles. done_o is high once
// quiet_i has been high for HOLD cycles and stays high until quiet_i drops.
// Assumes HOLD >= 1.
module lsd_quiet_timer #(
    parameter int HOLD = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet_i,
    output logic done_o
);
    localparam int            CW  = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == LIM);

    // Restart on activity, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!quiet_i) cnt_q <= '0;
        else if (!done_o)  cnt_q <= cnt_q + 1'b1;
    end

    // R4: the timer can only be complete after a quiet cycle
    a_r4_done_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(quiet_i));
endmodule

// File: rtl/lsd_diag_channel.sv
`timescale 1ns/1ps
// Module: supervisor for one low-side switch. It synchronises the inputs,
// qualifies the fault flags by switch state and filters them. It latches
// severe faults (switch off) and warnings (status only), and stretches the
// status off-transition. Assumes the analog comparators deliver level flags.
module lsd_diag_channel
    import lsd_diag_pkg::*;
#(
    parameter int FILT_CYC     = 16,
    parameter int FILT_OFF_CYC = 40,
    parameter int HOLD_CYC     = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ctl_i,
    input  logic ovl_i,
    input  logic otemp_i,
    input  logic pgnd_i,
    input  logic sgnd_i,
    input  logic ucur_i,
    input  logic uvolt_i,
    input  logic clamp_i,
    output logic gate_o,
    output logic stat_o
);
    localparam int SW = NFLAG + 2;

    logic [SW-1:0]    raw_bus, sync_bus;
    flag_vec_t        flg_s;
    logic             en_s, ctl_s, on_cmd, off_cmd;
    logic [NFILT-1:0] qual, hit;
    logic             severe, warn_now, rel_done, wq_done;
    logic             sd_lat, warn_lat, cmd_hold;

    assign raw_bus = {clamp_i, uvolt_i, ucur_i, sgnd_i, pgnd_i, otemp_i, ovl_i, ctl_i, en_i};

    lsd_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (sync_bus)
    );

    assign en_s    = sync_bus[0];
    assign ctl_s   = sync_bus[1];
    assign flg_s   = sync_bus[SW-1:2];
    assign on_cmd  = en_s & ctl_s;
    assign off_cmd = en_s & ~ctl_s;

    // Qualify each filtered flag by the switch state in which it is meaningful.
    always_comb begin
        qual           = '0;
        qual[FL_OVL]   = flg_s[FL_OVL] & on_cmd;
        qual[FL_OTEMP] = flg_s[FL_OTEMP];
        qual[FL_PGND]  = flg_s[FL_PGND];
        qual[FL_SGND]  = flg_s[FL_SGND];
        qual[FL_UCUR]  = flg_s[FL_UCUR] & on_cmd;
        qual[FL_UVOLT] = flg_s[FL_UVOLT] & off_cmd;
    end

    generate
        for (genvar i = 0; i < NFILT; i++) begin : g_filt
            localparam int LEN = (i == FL_UVOLT) ? FILT_OFF_CYC : FILT_CYC;
            lsd_flag_filter #(.LEN(LEN)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .flag_i (qual[i]),
                .hit_o  (hit[i])
            );
        end
    endgenerate

    assign severe   = |hit[FL_SGND:FL_OVL];
    assign warn_now = hit[FL_UCUR] | hit[FL_UVOLT] | flg_s[FL_CLAMP];

    lsd_quiet_timer #(.HOLD(HOLD_CYC)) u_rel_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .quiet_i (~on_cmd),
        .done_o  (rel_done)
    );

    lsd_quiet_timer #(.HOLD(HOLD_CYC)) u_warn_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .quiet_i (~warn_now),
        .done_o  (wq_done)
    );

    // Shutdown latch: set wins over release.
    always_ff @(posedge clk) begin
        if (!rst_n)        sd_lat <= 1'b0;
        else if (severe)   sd_lat <= 1'b1;
        else if (rel_done) sd_lat <= 1'b0;
    end

    // Warning register: self-clearing after a quiet interval.
    always_ff @(posedge clk) begin
        if (!rst_n)        warn_lat <= 1'b0;
        else if (warn_now) warn_lat <= 1'b1;
        else if (wq_done)  warn_lat <= 1'b0;
    end

    // Stretched commanded state: rises at once, falls after a long off phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd_hold <= 1'b0;
        else if (on_cmd)   cmd_hold <= 1'b1;
        else if (rel_done) cmd_hold <= 1'b0;
    end

    assign gate_o = on_cmd & ~sd_lat;
    assign stat_o = cmd_hold ^ (sd_lat | warn_lat);

    // R1: gate on needs enable and control high two edges earlier
    a_r1_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> ($past(en_i, 2) && $past(ctl_i, 2)));
    // R3: an accepted severe fault removes the gate on the next cycle
    a_r3_severe_kills_gate: assert property (@(posedge clk) disable iff (!rst_n)
        severe |=> !gate_o);
    // R4: the latch falls only when the release timer had completed
    a_r4_release_timed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_lat) |-> $past(rel_done));
    // R5: the warning register falls only after a full quiet interval
    a_r5_warn_clear_timed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_lat) |-> $past(wq_done));
    // R8: while commanded on, the stretched state is high next cycle
    a_r8_hold_follows_on: assert property (@(posedge clk) disable iff (!rst_n)
        on_cmd |=> cmd_hold);
endmodule

// File: tb/tb_lsd_diag_channel.sv
`timescale 1ns/1ps
// Bench: segment table walked by one loop, then directed corner cases.
// A cycle model built from the requirements is compared at every negedge.
module tb_lsd_diag_channel;
    localparam int TF  = 4;
    localparam int TFO = 8;
    localparam int TH  = 16;
    localparam int SEG = 40;
    localparam int NV  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ctl = 1'b0;
    logic [6:0] flt = '0;  // bit0 ovl,1 otemp,2 pgnd,3 sgnd,4 ucur,5 uvolt,6 clamp
    logic gate_o, stat_o;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    lsd_diag_channel #(.FILT_CYC(TF), .FILT_OFF_CYC(TFO), .HOLD_CYC(TH)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ctl_i(ctl),
        .ovl_i(flt[0]), .otemp_i(flt[1]), .pgnd_i(flt[2]), .sgnd_i(flt[3]),
        .ucur_i(flt[4]), .uvolt_i(flt[5]), .clamp_i(flt[6]),
        .gate_o(gate_o), .stat_o(stat_o)
    );

    // Reference model state
    logic [8:0] m_s1 = '0, m_s2 = '0;
    int         m_fc [6];
    logic [5:0] m_hit = '0;
    int         m_rel = 0, m_wq = 0;
    logic       m_sd = 1'b0, m_hold = 1'b0, m_wr = 1'b0;
    logic       m_gate, m_stat;

    assign m_gate = m_s2[0] & m_s2[1] & ~m_sd;
    assign m_stat = m_hold ^ (m_sd | m_wr);

    always @(posedge clk) begin : model
        logic on_c, off_c, sev, wn;
        logic [5:0] q;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_hit <= '0;
            for (int k = 0; k < 6; k++) m_fc[k] <= 0;
            m_rel <= 0; m_wq <= 0; m_sd <= 0; m_hold <= 0; m_wr <= 0;
        end else begin
            on_c  = m_s2[0] & m_s2[1];
            off_c = m_s2[0] & ~m_s2[1];
            q[0] = m_s2[2] & on_c;
            q[1] = m_s2[3];
            q[2] = m_s2[4];
            q[3] = m_s2[5];
            q[4] = m_s2[6] & on_c;
            q[5] = m_s2[7] & off_c;
            sev = |m_hit[3:0];
            wn  = m_hit[4] | m_hit[5] | m_s2[8];
            for (int k = 0; k < 6; k++) begin
                if (!q[k]) begin
                    m_fc[k] <= 0; m_hit[k] <= 1'b0;
                end else if (m_fc[k] == ((k == 5) ? TFO : TF) - 1) begin
                    m_hit[k] <= 1'b1;
                end else begin
                    m_fc[k] <= m_fc[k] + 1;
                end
            end
            m_sd   <= sev ? 1'b1 : ((m_rel == TH) ? 1'b0 : m_sd);
            m_hold <= on_c ? 1'b1 : ((m_rel == TH) ? 1'b0 : m_hold);
            m_rel  <= on_c ? 0 : ((m_rel == TH) ? TH : m_rel + 1);
            m_wr   <= wn ? 1'b1 : ((m_wq == TH) ? 1'b0 : m_wr);
            m_wq   <= wn ? 0 : ((m_wq == TH) ? TH : m_wq + 1);
            m_s1   <= {flt, ctl, en};
            m_s2   <= m_s1;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic run(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            chk(tag, "gate vs model", gate_o, m_gate);
            chk(tag, "status vs model", stat_o, m_stat);
        end
    endtask

    // {en, ctl, flags[6:0], expected gate, expected status} per segment
    localparam logic [10:0] VEC [NV] = '{
        11'b0_0_0000000_0_0, 11'b1_1_0000000_1_1, 11'b0_1_0000000_0_0,
        11'b1_0_0000000_0_0, 11'b1_1_0000001_0_0, 11'b1_1_0000000_0_0,
        11'b1_0_0000000_0_0, 11'b1_1_0000000_1_1, 11'b1_1_0010000_1_0,
        11'b1_1_0000000_1_1, 11'b1_0_0100000_0_1, 11'b1_0_0000001_0_0,
        11'b0_0_0000010_0_1, 11'b1_1_0000000_0_0, 11'b0_1_0000000_0_0,
        11'b1_1_0100000_1_1, 11'b1_1_1000000_1_0, 11'b1_1_0000100_0_0,
        11'b1_0_0001000_0_1, 11'b1_0_0000000_0_0
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 2:              return "R1";
            1, 3, 7:           return "R2";
            4, 17, 18:         return "R3";
            5, 6, 13, 14, 19:  return "R4";
            8, 9, 16:          return "R5";
            default:           return "R7";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [10:0] v;
        repeat (3) @(negedge clk);
        chk("R10", "reset gate", gate_o, 1'b0);
        chk("R10", "reset status", stat_o, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            en = v[10]; ctl = v[9]; flt = v[8:2];
            run(SEG, tag_of(i));
            chk(tag_of(i), "segment end gate", gate_o, v[1]);
            chk(tag_of(i), "segment end status", stat_o, v[0]);
        end

        // R6: overload glitch one sample short of the filter on a running switch
        en = 1; ctl = 1; flt = '0;
        run(SEG, "R6");
        flt[0] = 1'b1;
        repeat (TF - 1) begin @(negedge clk); chk("R6", "gate during glitch", gate_o, 1'b1); end
        flt[0] = 1'b0;
        repeat (20) begin @(negedge clk); chk("R6", "gate after glitch", gate_o, 1'b1); end

        // R8: PWM with low phases of 4 cycles keeps status high
        for (int p = 0; p < 10; p++) begin
            ctl = 1'b0;
            repeat (4) begin @(negedge clk); chk("R8", "status under PWM", stat_o, 1'b1); end
            ctl = 1'b1;
            repeat (4) begin @(negedge clk); chk("R8", "status under PWM", stat_o, 1'b1); end
        end

        // R4: latch an overload, then toggle the control faster than the release delay
        flt[0] = 1'b1;
        run(SEG, "R3");
        flt[0] = 1'b0;
        run(10, "R4");
        for (int p = 0; p < 10; p++) begin
            ctl = 1'b0;
            repeat (4) begin @(negedge clk); chk("R4", "gate held off", gate_o, 1'b0); end
            ctl = 1'b1;
            repeat (4) begin @(negedge clk); chk("R4", "gate held off", gate_o, 1'b0); end
        end
        ctl = 1'b0;
        run(SEG, "R4");
        ctl = 1'b1;
        run(SEG, "R4");
        chk("R4", "gate after release", gate_o, 1'b1);

        // R9: clamp pulses with gaps shorter than the hold keep status inverted
        for (int p = 0; p < 6; p++) begin
            flt[6] = 1'b1;
            repeat (2) begin
                @(negedge clk);
                if (p > 0) chk("R9", "status stays inverted", stat_o, 1'b0);
            end
            flt[6] = 1'b0;
            repeat (8) begin
                @(negedge clk);
                chk("R9", "status stays inverted", stat_o, 1'b0);
                chk("R9", "gate unaffected", gate_o, 1'b1);
            end
        end
        run(SEG, "R5");
        chk("R5", "status after warning clears", stat_o, 1'b1);

        // R10: reset while running, then two-edge input latency
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R10", "gate in reset", gate_o, 1'b0);
            chk("R10", "status in reset", stat_o, 1'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "gate one edge after reset", gate_o, 1'b0);
        @(negedge clk);
        chk("R10", "gate two edges after reset", gate_o, 1'b1);
        run(10, "R10");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule